// File: doc/BRIEF.md
# Keyed Indexed Configuration Register Bank

This block holds the configuration of a multi-function I/O peripheral: the enable, port addresses, interrupt routing and chip-select settings of each function, plus control bytes for its general-purpose pins. The host reaches it through two byte-wide I/O locations. Location 0 is the index/key port and location 1 is the data port. Out of reset the registers are locked. The host must write an unlock key to location 0 before any register can be seen or changed. A lock key written to the same location closes access again.

While unlocked, a byte written to location 0 (other than the lock key) becomes the current index. Accesses to location 1 then read or write the register at that index. A device-select register chooses which register bank answers indices at 0x30 and above. Five logical devices each have a bank: keyboard (0), serial A (1), serial B (2), disk channel A (3) and disk channel B (4). A global bank (number 8) holds the pin control bytes. Identification registers sit below 0x30 and answer whichever bank is selected. Every stored value is exported as a flat output vector to the function blocks. Reads are combinational: `io_rdata` always shows the register addressed by `io_addr`.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset the block is locked. All device activate outputs, base addresses, interrupt selects and chip-select bytes are 0. Every pin control byte is 0x01.
- R2: While locked, a write of the unlock key (default 0x55) to location 0 unlocks the block on the next cycle. Any other byte written to location 0 leaves it locked.
- R3: While unlocked, a write of the lock key (default 0xAA) to location 0 relocks the block. Any other byte written there becomes the current index, which reads back at location 0.
- R4: While locked, writes to location 1 change no register, and reads of either location return 0x00.
- R5: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to them are ignored.
- R6: Index 0x07 is the device-select register, readable and writable from any bank. Its value picks the bank that serves indices 0x30 and above, and writes reach only that bank.
- R7: Bit 0 of index 0x30 in device bank n drives `dev_active[n]`. That register reads back as 0x01 or 0x00.
- R8: The primary base is 16 bits, with the high byte at index 0x60 and the low byte at 0x61. A secondary base at 0x62/0x63 exists only in disk channel banks 3 and 4. In the other banks it reads 0 and ignores writes. Device n's base sits at bits [16n+15:16n] of its vector.
- R9: Index 0x70 holds each bank's primary interrupt select. Index 0x72 holds a secondary select that exists only in keyboard bank 0; elsewhere it reads 0 and ignores writes. Device n uses bits [8n+7:8n].
- R10: Indices 0xF0 and 0xF1 hold two full 8-bit chip-select control bytes per device bank.
- R11: In global bank 8, pin k's control byte sits at index 0xC0+k and stores 5 bits. The fields are: bit 0 direction (1 = input), bit 1 polarity invert, bit 2 combined-interrupt enable, bits 4:3 function select (00 default, 01 alternate 1). Bits 7:5 read as 0. Pin indices have no effect in device banks.
- R12: Unimplemented indices, and any index at or above 0x30 while the device select names no bank, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_addr | input | 1 | 0 = index/key location, 1 = data location |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte for the addressed location |
| cfg_unlocked | output | 1 | High while configuration access is open |
| dev_active | output | NDEV | Per-device enable |
| dev_base0 | output | 16*NDEV | Primary base address per device |
| dev_base1 | output | 16*NDEV | Secondary base address per device |
| dev_irq0 | output | 8*NDEV | Primary interrupt select per device |
| dev_irq1 | output | 8*NDEV | Secondary interrupt select per device |
| dev_cs0 | output | 8*NDEV | First chip-select control byte per device |
| dev_cs1 | output | 8*NDEV | Second chip-select control byte per device |
| gpio_is_input | output | NGPIO | Pin direction, 1 = input |
| gpio_invert | output | NGPIO | Pin polarity invert |
| gpio_irq_en | output | NGPIO | Pin combined-interrupt enable |
| gpio_func | output | 2*NGPIO | Pin function select, 2 bits per pin |

## Verification
Key handling is tried with the unlock key, with non-key bytes while locked, and with data-port writes while locked. This separates a correct lock from one that opens on any write or lets data through. Bank selection is tried by writing the same indices under several device numbers and checking that neighbouring banks keep their values. This catches a decoder that ignores the select or writes every bank. Feature-limited registers (secondary base, secondary interrupt), read-only identification, the 5-bit pin fields and indices with no register show whether each register is present only where it should be. Relocking after setup confirms that stored values survive and that the data port goes inert again.

// File: rtl/keyed_cfg_bank_pkg.sv
package keyed_cfg_bank_pkg;

    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_DEVID    = 8'h20;
    localparam logic [7:0] IDX_DEVREV   = 8'h21;
    localparam logic [7:0] IDX_BANK_LO  = 8'h30;
    localparam logic [7:0] IDX_ACT      = 8'h30;
    localparam logic [7:0] IDX_BASE0_HI = 8'h60;
    localparam logic [7:0] IDX_BASE0_LO = 8'h61;
    localparam logic [7:0] IDX_BASE1_HI = 8'h62;
    localparam logic [7:0] IDX_BASE1_LO = 8'h63;
    localparam logic [7:0] IDX_IRQ0     = 8'h70;
    localparam logic [7:0] IDX_IRQ1     = 8'h72;
    localparam logic [7:0] IDX_CS0      = 8'hF0;
    localparam logic [7:0] IDX_CS1      = 8'hF1;

    localparam logic [7:0] DEV_ID_VAL   = 8'h30;
    localparam logic [7:0] DEV_REV_VAL  = 8'h01;

    localparam int         PIN_CTL_W    = 5;
    localparam logic [PIN_CTL_W-1:0] PIN_CTL_RST = 5'b00001;

    typedef struct packed {
        logic        act;
        logic [15:0] base0;
        logic [15:0] base1;
        logic [7:0]  irq0;
        logic [7:0]  irq1;
        logic [7:0]  cs0;
        logic [7:0]  cs1;
    } bank_regs_t;

endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
    import keyed_cfg_bank_pkg::*;
#(
    parameter logic [7:0] ENTER_KEY = 8'h55,
    parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       port_sel,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index,
    output logic [7:0] ldn,
    output logic       data_wr
);

    typedef struct packed {
        logic       unlocked;
        logic [7:0] index;
        logic [7:0] ldn;
    } key_state_t;

    key_state_t st_d, st_q;

    assign data_wr = wr_en && port_sel && st_q.unlocked;

    always_comb begin
        st_d = st_q;
        if (wr_en && !port_sel) begin
            if (!st_q.unlocked) begin
                if (wdata == ENTER_KEY) begin
                    st_d.unlocked = 1'b1;
                end
            end else if (wdata == EXIT_KEY) begin
                st_d.unlocked = 1'b0;
            end else begin
                st_d.index = wdata;
            end
        end
        if (data_wr && (st_q.index == IDX_LDN)) begin
            st_d.ldn = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.unlocked;
    assign index    = st_q.index;
    assign ldn      = st_q.ldn;

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import keyed_cfg_bank_pkg::*;
#(
    parameter bit HAS_BASE1 = 1'b0,
    parameter bit HAS_IRQ1  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output bank_regs_t regs
);

    bank_regs_t r_d, r_q;
    logic       wr_hit;

    assign wr_hit = sel && wr_en;

    always_comb begin
        r_d = r_q;
        if (wr_hit) begin
            case (index)
                IDX_ACT:      r_d.act         = wdata[0];
                IDX_BASE0_HI: r_d.base0[15:8] = wdata;
                IDX_BASE0_LO: r_d.base0[7:0]  = wdata;
                IDX_BASE1_HI: if (HAS_BASE1) r_d.base1[15:8] = wdata;
                IDX_BASE1_LO: if (HAS_BASE1) r_d.base1[7:0]  = wdata;
                IDX_IRQ0:     r_d.irq0        = wdata;
                IDX_IRQ1:     if (HAS_IRQ1) r_d.irq1 = wdata;
                IDX_CS0:      r_d.cs0         = wdata;
                IDX_CS1:      r_d.cs1         = wdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (index)
            IDX_ACT:      rdata = {7'b0, r_q.act};
            IDX_BASE0_HI: rdata = r_q.base0[15:8];
            IDX_BASE0_LO: rdata = r_q.base0[7:0];
            IDX_BASE1_HI: rdata = r_q.base1[15:8];
            IDX_BASE1_LO: rdata = r_q.base1[7:0];
            IDX_IRQ0:     rdata = r_q.irq0;
            IDX_IRQ1:     rdata = r_q.irq1;
            IDX_CS0:      rdata = r_q.cs0;
            IDX_CS1:      rdata = r_q.cs1;
            default:      rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

endmodule

// File: rtl/cfg_pin_bank.sv
module cfg_pin_bank
    import keyed_cfg_bank_pkg::*;
#(
    parameter int         NGPIO     = 16,
    parameter logic [7:0] FIRST_IDX = 8'hC0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr_en,
    input  logic [7:0]         index,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [NGPIO-1:0]   pin_is_input,
    output logic [NGPIO-1:0]   pin_invert,
    output logic [NGPIO-1:0]   pin_irq_en,
    output logic [2*NGPIO-1:0] pin_func
);

    localparam int OFF_W = (NGPIO > 1) ? $clog2(NGPIO) : 1;

    logic [NGPIO-1:0][PIN_CTL_W-1:0] ctl_d, ctl_q;
    logic [7:0]       off;
    logic [OFF_W-1:0] slot;
    logic             hit;

    assign off  = index - FIRST_IDX;
    assign slot = off[OFF_W-1:0];
    assign hit  = (index >= FIRST_IDX) && (32'(off) < NGPIO);

    always_comb begin
        ctl_d = ctl_q;
        if (sel && wr_en && hit) begin
            ctl_d[slot] = wdata[PIN_CTL_W-1:0];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit) begin
            rdata = {{(8-PIN_CTL_W){1'b0}}, ctl_q[slot]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGPIO; i++) begin
                ctl_q[i] <= PIN_CTL_RST;
            end
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NGPIO; g++) begin : g_pin
        assign pin_is_input[g]    = ctl_q[g][0];
        assign pin_invert[g]      = ctl_q[g][1];
        assign pin_irq_en[g]      = ctl_q[g][2];
        assign pin_func[2*g +: 2] = ctl_q[g][4:3];
    end

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
    import keyed_cfg_bank_pkg::*;
#(
    parameter logic [7:0]      ENTER_KEY   = 8'h55,
    parameter logic [7:0]      EXIT_KEY    = 8'hAA,
    parameter int              NDEV        = 5,
    parameter logic [7:0]      GLOBAL_LDN  = 8'h08,
    parameter int              NGPIO       = 16,
    parameter logic [7:0]      PIN_IDX     = 8'hC0,
    parameter logic [NDEV-1:0] BASE1_MASK  = 5'b11000,
    parameter logic [NDEV-1:0] IRQ1_MASK   = 5'b00001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic                 io_addr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 cfg_unlocked,
    output logic [NDEV-1:0]      dev_active,
    output logic [16*NDEV-1:0]   dev_base0,
    output logic [16*NDEV-1:0]   dev_base1,
    output logic [8*NDEV-1:0]    dev_irq0,
    output logic [8*NDEV-1:0]    dev_irq1,
    output logic [8*NDEV-1:0]    dev_cs0,
    output logic [8*NDEV-1:0]    dev_cs1,
    output logic [NGPIO-1:0]     gpio_is_input,
    output logic [NGPIO-1:0]     gpio_invert,
    output logic [NGPIO-1:0]     gpio_irq_en,
    output logic [2*NGPIO-1:0]   gpio_func
);

    logic       unlocked;
    logic [7:0] cur_idx;
    logic [7:0] ldn;
    logic       data_wr;
    logic       bank_space;
    logic [7:0] bank_rdata [NDEV];
    logic [7:0] pin_rdata;
    logic [7:0] data_rd;

    cfg_key_ctrl #(
        .ENTER_KEY (ENTER_KEY),
        .EXIT_KEY  (EXIT_KEY)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr),
        .port_sel (io_addr),
        .wdata    (io_wdata),
        .unlocked (unlocked),
        .index    (cur_idx),
        .ldn      (ldn),
        .data_wr  (data_wr)
    );

    assign bank_space = (cur_idx >= IDX_BANK_LO);

    for (genvar k = 0; k < NDEV; k++) begin : g_dev
        bank_regs_t regs;

        cfg_dev_bank #(
            .HAS_BASE1 (BASE1_MASK[k]),
            .HAS_IRQ1  (IRQ1_MASK[k])
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (ldn == 8'(k)),
            .wr_en (data_wr && bank_space),
            .index (cur_idx),
            .wdata (io_wdata),
            .rdata (bank_rdata[k]),
            .regs  (regs)
        );

        assign dev_active[k]       = regs.act;
        assign dev_base0[16*k +: 16] = regs.base0;
        assign dev_base1[16*k +: 16] = regs.base1;
        assign dev_irq0[8*k +: 8]  = regs.irq0;
        assign dev_irq1[8*k +: 8]  = regs.irq1;
        assign dev_cs0[8*k +: 8]   = regs.cs0;
        assign dev_cs1[8*k +: 8]   = regs.cs1;
    end

    cfg_pin_bank #(
        .NGPIO     (NGPIO),
        .FIRST_IDX (PIN_IDX)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (ldn == GLOBAL_LDN),
        .wr_en        (data_wr && bank_space),
        .index        (cur_idx),
        .wdata        (io_wdata),
        .rdata        (pin_rdata),
        .pin_is_input (gpio_is_input),
        .pin_invert   (gpio_invert),
        .pin_irq_en   (gpio_irq_en),
        .pin_func     (gpio_func)
    );

    always_comb begin
        data_rd = 8'h00;
        if (cur_idx == IDX_LDN) begin
            data_rd = ldn;
        end else if (cur_idx == IDX_DEVID) begin
            data_rd = DEV_ID_VAL;
        end else if (cur_idx == IDX_DEVREV) begin
            data_rd = DEV_REV_VAL;
        end else if (bank_space) begin
            for (int k = 0; k < NDEV; k++) begin
                if (ldn == 8'(k)) begin
                    data_rd = bank_rdata[k];
                end
            end
            if (ldn == GLOBAL_LDN) begin
                data_rd = pin_rdata;
            end
        end
    end

    always_comb begin
        if (!unlocked) begin
            io_rdata = 8'h00;
        end else if (io_addr) begin
            io_rdata = data_rd;
        end else begin
            io_rdata = cur_idx;
        end
    end

    assign cfg_unlocked = unlocked;

endmodule

// File: rtl/keyed_cfg_bank_chk.sv
module keyed_cfg_bank_chk #(
    parameter logic [7:0] ENTER_KEY = 8'h55,
    parameter logic [7:0] EXIT_KEY  = 8'hAA,
    parameter int         NDEV      = 5,
    parameter int         NGPIO     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_wr,
    input logic               io_addr,
    input logic [7:0]         io_wdata,
    input logic [7:0]         io_rdata,
    input logic               cfg_unlocked,
    input logic [NDEV-1:0]    dev_active,
    input logic [16*NDEV-1:0] dev_base0,
    input logic [NGPIO-1:0]   gpio_is_input,
    input logic [7:0]         cur_idx
);

    AST_ENTER_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_wr && !io_addr && io_wdata == ENTER_KEY) |=> cfg_unlocked); // R2

    AST_OTHER_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_wr && !io_addr && io_wdata != ENTER_KEY) |=> !cfg_unlocked); // R2

    AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && !io_addr && io_wdata == EXIT_KEY) |=> !cfg_unlocked); // R3

    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && !io_addr && io_wdata != EXIT_KEY) |=> (cur_idx == $past(io_wdata))); // R3

    AST_LOCKED_DATA_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_wr && io_addr) |=>
            ($stable(dev_active) && $stable(dev_base0) && $stable(gpio_is_input))); // R4

    AST_LOCKED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |-> (io_rdata == 8'h00)); // R4

    AST_DEVID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_addr && cur_idx == 8'h20) |-> (io_rdata == 8'h30)); // R5

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(dev_active)); // R7

endmodule

bind keyed_cfg_bank keyed_cfg_bank_chk #(
    .ENTER_KEY (ENTER_KEY),
    .EXIT_KEY  (EXIT_KEY),
    .NDEV      (NDEV),
    .NGPIO     (NGPIO)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .cfg_unlocked  (cfg_unlocked),
    .dev_active    (dev_active),
    .dev_base0     (dev_base0),
    .gpio_is_input (gpio_is_input),
    .cur_idx       (cur_idx)
);

// File: tb/keyed_cfg_bank_tb.sv
module keyed_cfg_bank_tb;

    localparam int NDEV  = 5;
    localparam int NGPIO = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 io_wr = 1'b0;
    logic                 io_addr = 1'b0;
    logic [7:0]           io_wdata = 8'h00;
    logic [7:0]           io_rdata;
    logic                 cfg_unlocked;
    logic [NDEV-1:0]      dev_active;
    logic [16*NDEV-1:0]   dev_base0, dev_base1;
    logic [8*NDEV-1:0]    dev_irq0, dev_irq1, dev_cs0, dev_cs1;
    logic [NGPIO-1:0]     gpio_is_input, gpio_invert, gpio_irq_en;
    logic [2*NGPIO-1:0]   gpio_func;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    keyed_cfg_bank u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_wr         (io_wr),
        .io_addr       (io_addr),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .cfg_unlocked  (cfg_unlocked),
        .dev_active    (dev_active),
        .dev_base0     (dev_base0),
        .dev_base1     (dev_base1),
        .dev_irq0      (dev_irq0),
        .dev_irq1      (dev_irq1),
        .dev_cs0       (dev_cs0),
        .dev_cs1       (dev_cs1),
        .gpio_is_input (gpio_is_input),
        .gpio_invert   (gpio_invert),
        .gpio_irq_en   (gpio_irq_en),
        .gpio_func     (gpio_func)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] val);
        wr(1'b0, idx);
        wr(1'b1, val);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] val);
        wr(1'b0, idx);
        rd(1'b1, val);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 locked", cfg_unlocked, 0);
        check("R1 active", dev_active, 0);
        check("R1 base0", dev_base0, 0);
        check("R1 irq/cs", {dev_irq0, dev_cs0}, 0);
        check("R1 pin input", gpio_is_input, {NGPIO{1'b1}});
        check("R1 pin func", gpio_func, 0);
        rd(1'b1, v);
        check("R4 locked read", v, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h54);
        check("R2 non-key stays locked", cfg_unlocked, 0);
        check("R4 locked write inert", dev_active, 0);
        rd(1'b0, v);
        check("R4 locked index read", v, 8'h00);
        rd(1'b1, v);
        check("R4 locked data read", v, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        wr(1'b0, 8'h55);
        check("R2 unlock", cfg_unlocked, 1);
        reg_rd(8'h20, v);
        check("R5 device id", v, 8'h30);
        rd(1'b0, v);
        check("R3 index echo", v, 8'h20);
        reg_rd(8'h21, v);
        check("R5 revision", v, 8'h01);
        reg_wr(8'h20, 8'h99);
        rd(1'b1, v);
        check("R5 id read-only", v, 8'h30);
    endtask

    task automatic t_serial_a();
        logic [7:0] v;
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h07, v);
        check("R6 select readback", v, 8'h01);
        reg_wr(8'h30, 8'h01);
        check("R7 activate dev1", dev_active, 5'b00010);
        rd(1'b1, v);
        check("R7 activate readback", v, 8'h01);
        reg_wr(8'h60, 8'h03);
        reg_wr(8'h61, 8'hF8);
        check("R8 base0 dev1", dev_base0[31:16], 16'h03F8);
        reg_rd(8'h61, v);
        check("R8 base0 low readback", v, 8'hF8);
        reg_wr(8'h70, 8'h04);
        check("R9 irq0 dev1", dev_irq0[15:8], 8'h04);
    endtask

    task automatic t_isolation();
        logic [7:0] v;
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h60, 8'h02);
        reg_wr(8'h61, 8'hF8);
        check("R6 dev2 written", dev_base0[47:32], 16'h02F8);
        check("R6 dev1 untouched", dev_base0[31:16], 16'h03F8);
        reg_rd(8'h30, v);
        check("R7 dev2 inactive", v, 8'h00);
    endtask

    task automatic t_secondary();
        logic [7:0] v;
        reg_wr(8'h07, 8'h01);
        reg_wr(8'h62, 8'h12);
        rd(1'b1, v);
        check("R8 base1 absent readback", v, 8'h00);
        check("R8 base1 absent output", dev_base1[31:16], 16'h0000);
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h62, 8'h03);
        reg_wr(8'h63, 8'hF6);
        check("R8 base1 dev3", dev_base1[63:48], 16'h03F6);
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h72, 8'h0C);
        check("R9 irq1 keyboard", dev_irq1[7:0], 8'h0C);
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h72, 8'h05);
        rd(1'b1, v);
        check("R9 irq1 absent", {v, dev_irq1[23:16]}, 16'h0000);
    endtask

    task automatic t_chipsel();
        logic [7:0] v;
        reg_wr(8'h07, 8'h03);
        reg_wr(8'hF0, 8'h0C);
        reg_wr(8'hF1, 8'hA5);
        check("R10 cs0 dev3", dev_cs0[31:24], 8'h0C);
        check("R10 cs1 dev3", dev_cs1[31:24], 8'hA5);
        reg_rd(8'hF1, v);
        check("R10 cs1 readback", v, 8'hA5);
    endtask

    task automatic t_pins();
        logic [7:0] v;
        reg_wr(8'h07, 8'h01);
        reg_wr(8'hC3, 8'h00);
        check("R11 pin index in device bank", gpio_is_input[3], 1'b1);
        reg_wr(8'h07, 8'h08);
        reg_wr(8'hC2, 8'h00);
        check("R11 pin2 output", gpio_is_input[2], 1'b0);
        reg_wr(8'hC5, 8'h0E);
        check("R11 pin5 fields", {gpio_is_input[5], gpio_invert[5], gpio_irq_en[5], gpio_func[11:10]},
              {1'b0, 1'b1, 1'b1, 2'b01});
        reg_wr(8'hC7, 8'hFF);
        rd(1'b1, v);
        check("R11 pin byte width", v, 8'h1F);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h50, 8'h77);
        rd(1'b1, v);
        check("R12 hole reads zero", v, 8'h00);
        reg_wr(8'h07, 8'h06);
        reg_wr(8'h30, 8'h01);
        rd(1'b1, v);
        check("R12 empty select read", v, 8'h00);
        check("R12 empty select inert", dev_active, 5'b00010);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        reg_wr(8'h07, 8'h01);
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hAA);
        check("R3 relock", cfg_unlocked, 0);
        wr(1'b1, 8'h00);
        check("R4 relocked write inert", dev_active, 5'b00010);
        rd(1'b1, v);
        check("R4 relocked read", v, 8'h00);
        wr(1'b0, 8'h55);
        reg_rd(8'h30, v);
        check("R7 value kept over relock", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_ident();
        t_serial_a();
        t_isolation();
        t_secondary();
        t_chipsel();
        t_pins();
        t_unimpl();
        t_relock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule